// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A watchdog counter whose single 16-bit control word can only be rewritten after software presents a two-word unlock key on the write port. A second, separate two-word key restarts the count without touching the configuration. Once armed, the counter advances one step per clock. If it reaches the terminal value chosen by the control word before it is restarted, the block raises a one-cycle timeout pulse and latches a sticky expiry flag.

The timeout length is a power of two. The exponent is picked by a one-hot field in the control word, starting from a base exponent `BASE_EXP`. To change the timeout, software normally writes 0 under one unlock sequence and then writes the new word under a second one. Every write arrives on one port. The block keeps track of which key step it has reached.

Top module: `wdt_keyed`

## Requirements
- R1: A write of 0x3333 followed by a write of 0xCCCC as the next write opens the control register. The write after that is stored as the control word and appears on `ctrl_o` in the cycle after it is sampled.
- R2: An opened control register accepts exactly one write. The next write after that one is not stored.
- R3: A write of 0xAAAA followed by a write of 0x5555 as the next write restarts the count from zero. The control word is left unchanged, so the next timeout comes a full period after the 0x5555 write.
- R4: If the second word of a key sequence does not match, the sequence is abandoned and the mismatching write has no effect. A completing word that arrives after such a break does nothing.
- R5: A write that follows no unlock is ignored. It does not change `ctrl_o`, and it does not open the register for a later write.
- R6: The watchdog counts only when bits 15 and 14 of the control word are both 1. Otherwise the counter is held at zero and no timeout occurs.
- R7: Control bits SEL_W:1 form the period field. Bit k+1 selects a period of 2^(BASE_EXP+k) cycles. If several bits are set, the lowest set bit wins. If none is set, the counter stays at zero.
- R8: `timeout_o` is high for exactly one cycle, 2^n cycles after the write that armed or restarted the count. The count then starts again from zero, so pulses repeat every 2^n cycles.
- R9: `expired_o` goes high together with the first timeout pulse and stays high until reset, even after the watchdog is disabled.
- R10: Every accepted control write restarts the count from zero.
- R11: After reset, `ctrl_o` is 0, `timeout_o` is 0, `expired_o` is 0, and the key tracker is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control address |
| wr_data_i | input | 16 | Written word |
| ctrl_o | output | 16 | Current control word |
| timeout_o | output | 1 | One-cycle timeout pulse |
| expired_o | output | 1 | Sticky timeout flag |

## Verification
The bench breaks key sequences in the middle and then sends the completing word. A tracker that tolerated the stray word would load a control value or restart the count where it should not. It writes twice after a single unlock, and it writes with no unlock at all; a register left open would show the second value on `ctrl_o`. Timeout distances are measured from the exact edge of the arming, restart or rewrite. A counter that missed a restart, decoded the wrong field bit, chose the highest set bit instead of the lowest, or counted with only one enable bit set would miss the expected cycle by a whole period. After disabling, the bench confirms that the expiry flag is still set.

// File: rtl/wdt_key_pkg.sv
package wdt_key_pkg;
  localparam logic [15:0] KEY_UNLK_A = 16'h3333;
  localparam logic [15:0] KEY_UNLK_B = 16'hCCCC;
  localparam logic [15:0] KEY_KICK_A = 16'hAAAA;
  localparam logic [15:0] KEY_KICK_B = 16'h5555;
  localparam int unsigned EN_HI = 15;
  localparam int unsigned EN_LO = 14;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_UNLK_HALF,
    SEQ_OPEN,
    SEQ_KICK_HALF
  } seq_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_key_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic        ctrl_we_o,
  output logic        kick_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    ctrl_we_o = 1'b0;
    kick_o    = 1'b0;
    if (wr_en_i) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (wr_data_i == KEY_UNLK_A)      state_d = SEQ_UNLK_HALF;
          else if (wr_data_i == KEY_KICK_A) state_d = SEQ_KICK_HALF;
        end
        SEQ_UNLK_HALF: state_d = (wr_data_i == KEY_UNLK_B) ? SEQ_OPEN : SEQ_IDLE;
        SEQ_OPEN: begin
          ctrl_we_o = 1'b1;
          state_d   = SEQ_IDLE;
        end
        SEQ_KICK_HALF: begin
          kick_o  = (wr_data_i == KEY_KICK_B);
          state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  // one write only through an open lock
  assert_open_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_OPEN && wr_en_i) |=> state_q == SEQ_IDLE);
  // a kick never coincides with a control load
  assert_kick_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(kick_o && ctrl_we_o));
  // state moves only on a write
  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(state_q));
endmodule

// File: rtl/wdt_sel_decode.sv
module wdt_sel_decode #(
  parameter int unsigned BASE_EXP = 24,
  parameter int unsigned SEL_W    = 8,
  localparam int unsigned CW      = BASE_EXP + SEL_W - 1
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic             valid_o,
  output logic [CW-1:0]    last_o
);
  logic [CW-1:0] term_c [SEL_W];

  for (genvar k = 0; k < SEL_W; k++) begin : g_term
    assign term_c[k] = CW'((64'd1 << (BASE_EXP + k)) - 64'd1);
  end

  always_comb begin
    last_o = '0;
    for (int k = SEL_W - 1; k >= 0; k--) begin
      if (sel_i[k]) last_o = term_c[k];  // lowest set bit wins
    end
  end

  assign valid_o = |sel_i;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CW = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          restart_i,
  input  logic [CW-1:0] last_i,
  output logic          timeout_o,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;
  logic          hit;

  assign hit = en_i && !restart_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      timeout_o <= 1'b0;
      expired_o <= 1'b0;
    end else begin
      if (!en_i || restart_i || hit) cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
      timeout_o <= hit;
      expired_o <= expired_o | hit;
    end
  end

  assert_hold_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  assert_restart_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |=> expired_o);
  assert_pulse_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> expired_o);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_key_pkg::*;
#(
  parameter int unsigned BASE_EXP = 24,
  parameter int unsigned SEL_W    = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] ctrl_o,
  output logic        timeout_o,
  output logic        expired_o
);
  localparam int unsigned CW = BASE_EXP + SEL_W - 1;

  logic          ctrl_we, kick;
  logic [15:0]   ctrl_q;
  logic          sel_valid, en_all;
  logic [CW-1:0] last_val;

  wdt_key_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_we_o (ctrl_we),
    .kick_o    (kick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wr_data_i;
  end

  wdt_sel_decode #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_dec (
    .sel_i   (ctrl_q[SEL_W:1]),
    .valid_o (sel_valid),
    .last_o  (last_val)
  );

  assign en_all = ctrl_q[EN_HI] && ctrl_q[EN_LO] && sel_valid;

  wdt_counter #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_all),
    .restart_i (kick | ctrl_we),
    .last_i    (last_val),
    .timeout_o (timeout_o),
    .expired_o (expired_o)
  );

  assign ctrl_o = ctrl_q;

  assert_ctrl_by_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(wr_en_i));
  assert_no_timeout_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_q[EN_HI] && ctrl_q[EN_LO]) |=> !timeout_o);

  initial assert_sel_fits_R7: assert (SEL_W >= 1 && SEL_W <= 13 && BASE_EXP >= 1);
endmodule

// File: tb/sim_wdt_keyed.sv
module sim_wdt_keyed;
  localparam int unsigned BASE_EXP = 4;
  localparam int unsigned SEL_W    = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_o;
  logic        timeout_o, expired_o;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  wdt_keyed #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ctrl_o(ctrl_o), .timeout_o(timeout_o), .expired_o(expired_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wr_en  = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock_wr(input logic [15:0] d);
    wr(16'h3333); wr(16'hCCCC); wr(d);
  endtask

  task automatic kick();
    wr(16'hAAAA); wr(16'h5555);
  endtask

  // negedges until the pulse appears (0 if none within lim)
  task automatic measure(input int lim, output int c);
    int i = 0;
    c = 0;
    while (i < lim) begin
      @(negedge clk);
      i++;
      if (timeout_o) begin c = i; break; end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 ctrl", ctrl_o, 0);
    chk("R11 timeout", timeout_o, 0);
    chk("R11 expired", expired_o, 0);
  endtask

  task automatic t_unlock();
    do_reset();
    unlock_wr(16'hC004);
    chk("R1 load", ctrl_o, 16'hC004);
    wr(16'hC008);
    chk("R2 second write", ctrl_o, 16'hC004);
    unlock_wr(16'hC008);
    chk("R1 reload", ctrl_o, 16'hC008);
  endtask

  task automatic t_no_unlock();
    do_reset();
    wr(16'hC002);
    chk("R5 plain write", ctrl_o, 0);
    wr(16'hC004);
    chk("R5 no open", ctrl_o, 0);
  endtask

  task automatic t_broken();
    int c;
    do_reset();
    wr(16'h3333); wr(16'h1234); wr(16'hCCCC); wr(16'hC008);
    chk("R4 broken unlock", ctrl_o, 0);
    wr(16'h3333); wr(16'hAAAA); wr(16'h5555);
    chk("R4 mixed keys", ctrl_o, 0);
    unlock_wr(16'hC002);
    repeat (4) @(negedge clk);
    wr(16'hAAAA); wr(16'h1234); wr(16'h5555);
    measure(100, c);
    chk("R4 broken kick", c, 16 - 7);
    chk("R4 ctrl kept", ctrl_o, 16'hC002);
  endtask

  task automatic t_kick();
    int c;
    do_reset();
    unlock_wr(16'hC002);
    repeat (10) @(negedge clk);
    chk("R3 no early", timeout_o, 0);
    kick();
    measure(100, c);
    chk("R3 period after kick", c, 16);
    chk("R3 ctrl kept", ctrl_o, 16'hC002);
  endtask

  task automatic t_periodic();
    int c;
    do_reset();
    unlock_wr(16'hC004);
    measure(200, c);
    chk("R8 first pulse", c, 32);
    chk("R9 expired set", expired_o, 1);
    @(negedge clk);
    chk("R8 pulse width", timeout_o, 0);
    measure(200, c);
    chk("R8 repeat", c, 31);
    unlock_wr(16'h0000);
    repeat (100) @(negedge clk);
    chk("R9 sticky", expired_o, 1);
    chk("R6 off no pulse", timeout_o, 0);
  endtask

  task automatic t_select();
    int c;
    do_reset();
    unlock_wr(16'hC008);
    measure(200, c);
    chk("R7 bit3", c, 64);
    unlock_wr(16'hC00A);
    measure(200, c);
    chk("R7 lowest wins", c, 16);
    unlock_wr(16'hC100);
    measure(3000, c);
    chk("R7 top bit", c, 2048);
  endtask

  task automatic t_disabled();
    int c;
    do_reset();
    unlock_wr(16'h8002);
    measure(300, c);
    chk("R6 one enable bit", c, 0);
    unlock_wr(16'h4002);
    measure(300, c);
    chk("R6 other enable bit", c, 0);
    unlock_wr(16'hC000);
    measure(300, c);
    chk("R7 empty field", c, 0);
    chk("R6 no expiry", expired_o, 0);
  endtask

  task automatic t_rewrite();
    int c;
    do_reset();
    unlock_wr(16'hC008);
    repeat (30) @(negedge clk);
    unlock_wr(16'hC008);
    measure(200, c);
    chk("R10 rewrite restarts", c, 64);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_unlock();
    t_no_unlock();
    t_broken();
    t_kick();
    t_periodic();
    t_select();
    t_disabled();
    t_rewrite();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule